// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

A 16-bit up-counting timer whose single trigger line is used to keep slave timers in step with it. A 3-bit mode field picks what drives that line. It can be a command pulse from software, the counter-enable level, the counter update event, or a pulse on each channel-1 compare match. It can also be one of four compare reference waveforms. The line is registered, so every source reaches it one clock later.

Software configures the block through a simple write port. There are registers for the control bits (mode and enable), the auto-reload limit and four compare values, plus a command location that forces the counter back to zero. Counting runs when the software enable bit is set or when the external gate input is high. A two-state machine controls the counter. In HALT the count holds. In RUN the count advances once per clock and wraps from the auto-reload value to zero. The START transition (HALT to RUN) is taken on the edge after the enable goes high. The STOP transition (RUN to HALT) is taken on the edge after it goes low.

Top module: `trig_master_timer`

## Requirements
- R1: Write map: address 0 holds the mode in bits 2:0 and the software enable in bit 3; address 1 holds the auto-reload limit; addresses 2, 3, 4 and 5 hold compare values 1 to 4. A write to address 6 with bit 0 set is the software update request.
- R2: A software update request clears the counter on the edge it is written. In mode 000 the trigger output is high for exactly the one cycle after that edge.
- R3: Counter enable is the OR of the software enable bit and gate_in. The state machine enters RUN on the edge after enable rises. The count first advances on the following edge. In HALT the count does not change.
- R4: In mode 001 the trigger output follows counter enable one cycle late. A change on gate_in is not visible at trig_out until the next clock edge.
- R5: While in RUN, the count wraps from the auto-reload value to zero. Each wrap, and each software update request, is a one-cycle update event. Mode 010 puts update events on the trigger output.
- R6: In mode 011 the trigger output gives a one-cycle pulse after every RUN cycle in which the count equals compare value 1. This repeats in every counter period, with no flag that blocks it.
- R7: Compare reference i is high while the count is below compare value i and low otherwise. Modes 100, 101, 110 and 111 select references 1, 2, 3 and 4.
- R8: The trigger output is registered: after each edge it shows the chosen source as it was before that edge.
- R9: After reset, all registers are zero, the machine is in HALT, and trig_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| gate_in | input | 1 | Gated-mode slave trigger, ORed into counter enable |
| trig_out | output | 1 | Registered master trigger output |

## Verification
A software update request takes effect on the edge where it is written: the count is zero after that edge, and in modes 000 and 010 trig_out is high after that same edge. For any count value c held after edge n, the compare, match and wrap sources reach trig_out after edge n+1. So the bench issues the update request at a known edge T0 and expects the value computed from (k-1) mod (limit+1) after edge T0+k. Gate changes reach trig_out one edge later in mode 001, and counting starts two edges after enable rises. The bench drives stimulus and samples on the falling edge, so each check reads the state after exactly the counted number of rising edges.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int N_CMP  = 4;

    typedef enum logic [2:0] {
        TM_SWUG    = 3'b000,
        TM_ENABLE  = 3'b001,
        TM_UPDATE  = 3'b010,
        TM_CCPULSE = 3'b011,
        TM_REF1    = 3'b100,
        TM_REF2    = 3'b101,
        TM_REF3    = 3'b110,
        TM_REF4    = 3'b111
    } trig_mode_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } cnt_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_ARR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd6;
endpackage

// File: rtl/trig_regs.sv
module trig_regs
    import trig_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W,
    parameter int NC = N_CMP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [W-1:0]         wr_data,
    output trig_mode_e           mode,
    output logic                 sw_en,
    output logic [W-1:0]         arr,
    output logic [NC-1:0][W-1:0] cmp,
    output logic                 ug
);
    // control register: mode and software enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= TM_SWUG;
            sw_en <= 1'b0;
        end else if (wr_en && wr_addr == A_CTRL) begin
            mode  <= trig_mode_e'(wr_data[2:0]);
            sw_en <= wr_data[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            arr <= '0;
        else if (wr_en && wr_addr == A_ARR)
            arr <= wr_data;
    end

    // one register per compare channel
    for (genvar i = 0; i < NC; i++) begin : g_cmp
        localparam logic [AW-1:0] MY_ADDR = AW'(int'(A_CMP0) + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cmp[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                cmp[i] <= wr_data;
        end
    end

    // command strobe, acts on the edge it is written
    assign ug = wr_en && (wr_addr == A_CMD) && wr_data[0];
endmodule

// File: rtl/trig_counter.sv
module trig_counter
    import trig_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         ug,
    input  logic [W-1:0] arr,
    input  logic [W-1:0] cmp1,
    output logic [W-1:0] cnt,
    output logic         upd_evt,
    output logic         cc1_evt
);
    cnt_state_e st_q, st_d;
    logic       wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    // transitions: START (HALT->RUN) and STOP (RUN->HALT)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (cnt_en)  st_d = ST_RUN;
            ST_RUN:  if (!cnt_en) st_d = ST_HALT;
            default: st_d = ST_HALT;
        endcase
    end

    assign wrap = (st_q == ST_RUN) && (cnt == arr) && !ug;

    // count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (ug)
            cnt <= '0;
        else if (st_q == ST_RUN)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // event outputs
    always_comb begin
        upd_evt = ug || wrap;
        cc1_evt = (st_q == ST_RUN) && (cnt == cmp1);
    end

    AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == '0)); // R2
    AST_HOLD_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !ug) |=> $stable(cnt)); // R3
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && cnt == arr && !ug) |=> (cnt == '0)); // R5
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && !ug && arr != '0) |=> (!upd_evt || ug || $changed(arr))); // R5
endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NC = N_CMP
) (
    input  logic [W-1:0]         cnt,
    input  logic [NC-1:0][W-1:0] cmp,
    output logic [NC-1:0]        oref
);
    // pulse-width style: high while below the compare value
    for (genvar i = 0; i < NC; i++) begin : g_ref
        assign oref[i] = (cnt < cmp[i]);
    end
endmodule

// File: rtl/trig_sel.sv
module trig_sel
    import trig_pkg::*;
#(
    parameter int NC = N_CMP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  trig_mode_e    mode,
    input  logic          ug,
    input  logic          cnt_en,
    input  logic          upd_evt,
    input  logic          cc1_evt,
    input  logic [NC-1:0] oref,
    output logic          trig_out
);
    logic trig_d;

    always_comb begin
        trig_d = 1'b0;
        unique case (mode)
            TM_SWUG:    trig_d = ug;
            TM_ENABLE:  trig_d = cnt_en;
            TM_UPDATE:  trig_d = upd_evt;
            TM_CCPULSE: trig_d = cc1_evt;
            TM_REF1:    trig_d = oref[0];
            TM_REF2:    trig_d = oref[1];
            TM_REF3:    trig_d = oref[2];
            TM_REF4:    trig_d = oref[3];
            default:    trig_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_out <= 1'b0;
        else        trig_out <= trig_d;
    end

    AST_ENABLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_ENABLE && $stable(mode)) |=> (trig_out == $past(cnt_en))); // R4
    AST_SWUG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_SWUG && !ug) |=> !trig_out); // R2
endmodule

// File: rtl/trig_master_timer.sv
module trig_master_timer
    import trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              gate_in,
    output logic              trig_out
);
    trig_mode_e                  mode;
    logic                        sw_en, ug, cnt_en, upd_evt, cc1_evt;
    logic [CNT_W-1:0]            arr, cnt;
    logic [N_CMP-1:0][CNT_W-1:0] cmp;
    logic [N_CMP-1:0]            oref;

    trig_regs #(.W(CNT_W), .AW(ADDR_W), .NC(N_CMP)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .sw_en(sw_en), .arr(arr),
        .cmp(cmp), .ug(ug)
    );

    assign cnt_en = sw_en | gate_in;

    trig_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ug(ug), .arr(arr),
        .cmp1(cmp[0]), .cnt(cnt), .upd_evt(upd_evt), .cc1_evt(cc1_evt)
    );

    trig_cmp #(.W(CNT_W), .NC(N_CMP)) u_cmp (
        .cnt(cnt), .cmp(cmp), .oref(oref)
    );

    trig_sel #(.NC(N_CMP)) u_sel (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ug(ug), .cnt_en(cnt_en),
        .upd_evt(upd_evt), .cc1_evt(cc1_evt), .oref(oref), .trig_out(trig_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk) $rose(rst_n) |-> !trig_out); // R9
endmodule

// File: tb/trig_master_timer_bench.sv
module trig_master_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        gate_in = 1'b0;
    logic        trig_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam int ARR = 4;
    localparam int P   = ARR + 1;

    always #5 clk = ~clk;

    trig_master_timer u_trig_master_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gate_in(gate_in), .trig_out(trig_out)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (trig_out !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: trig_out=%b expected %b", req, $time, trig_out, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // select mode and enable, then update request at edge T0
    task automatic start(input logic [2:0] m, input logic en);
        wr(3'd0, {12'd0, en, m});
        wr(3'd6, 16'd1);
    endtask

    task automatic t_reset();
        chk("R9 reset", 1'b0);
        @(negedge clk);
        chk("R9 reset hold", 1'b0);
    endtask

    task automatic t_swug();
        start(3'b000, 1'b1);
        chk("R2 swug pulse", 1'b1);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R2 swug single", 1'b0);
        end
    endtask

    task automatic t_enable();
        wr(3'd0, {12'd0, 1'b0, 3'b001});
        @(negedge clk);
        chk("R4 enable low", 1'b0);
        gate_in = 1'b1;
        #1 chk("R4 gate not yet", 1'b0);
        @(negedge clk);
        chk("R4 gate high", 1'b1);
        gate_in = 1'b0;
        @(negedge clk);
        chk("R4 gate low", 1'b0);
        wr(3'd0, {12'd0, 1'b1, 3'b001});
        chk("R4 sw enable lag", 1'b0);
        @(negedge clk);
        chk("R4 sw enable", 1'b1);
    endtask

    task automatic t_update();
        start(3'b010, 1'b1);
        chk("R5 update by request", 1'b1);
        for (int k = 1; k <= 2 * P; k++) begin
            @(negedge clk);
            chk("R5 update on wrap", ((k - 1) % P) == ARR);
        end
    endtask

    task automatic t_ccpulse();
        start(3'b011, 1'b1);
        for (int k = 1; k <= 3 * P; k++) begin
            @(negedge clk);
            chk("R6 compare pulse", ((k - 1) % P) == 2);
        end
    endtask

    task automatic t_refs();
        int lim [4] = '{2, 3, 0, 5};
        for (int m = 0; m < 4; m++) begin
            start(3'(4 + m), 1'b1);
            for (int k = 1; k <= 2 * P; k++) begin
                @(negedge clk);
                chk("R7 R8 reference", ((k - 1) % P) < lim[m]);
            end
        end
    endtask

    task automatic t_hold();
        wr(3'd5, 16'd1);
        start(3'b111, 1'b0);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R3 hold in HALT", 1'b1);
        end
        gate_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 start latency", 1'b1);
        @(negedge clk);
        chk("R3 counting after START", 1'b0);
        gate_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R1 register map: limit, then compare values 1..4
        wr(3'd1, 16'(ARR));
        wr(3'd2, 16'd2);
        wr(3'd3, 16'd3);
        wr(3'd4, 16'd0);
        wr(3'd5, 16'd5);
        t_swug();
        t_enable();
        t_update();
        t_ccpulse();
        t_refs();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule